// File: doc/BRIEF.md
# SPI Target Port with Error Detection

This block is the target side of a four-wire SPI link. An external controller drives the serial clock, the select line and the data-in pin. While select is active, the block moves one bit in and one bit out per serial clock cycle. The pins are brought into the system clock domain through synchronizer chains, and all serial clock edges are found in that domain, so the block has a single clock. Clock polarity, clock phase, word length (8, 16 or 32 bits), bit order and the active level of select can all be configured.

The local logic places the next outgoing word on a load port. It collects each complete incoming word from a receive port that has a valid flag and an acknowledge input. There are two error conditions, and each sets a sticky flag:
- a **mode fault** is raised when select drops partway through a word;
- an **overrun** is raised when a word completes while the previous one is still unread.

Both flags stay set until the clear input is pulsed.

Top module: `spis_top`

## Requirements
- R1: After reset, rxValid, modeFault, overrun, misoOe and miso are all 0.
- R2: The active level of select follows cfgSsActHigh (1 = active high, 0 = active low). While select is inactive, misoOe is 0 and miso is 0.
- R3: The four clock modes work, with cfgCpol giving the idle level of sck and cfgCpha choosing the sampling edge (0 = first edge after idle, 1 = second edge). In every mode the block samples mosi on the sampling edge, and the controller sees valid miso data at that same edge.
- R4: cfgLen sets the word length: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. A received word is right-aligned in rxData, with the upper bits at zero.
- R5: cfgLsbFirst = 1 sends and receives the least significant bit first. With 0, the most significant bit goes first.
- R6: txLoad captures txData into a holding word. That word is loaded into the output shifter when select becomes active and at each word boundary within a select period. If it is not reloaded, the same word is sent again.
- R7: rxValid is set when a word completes and is cleared by a pulse on rxAck.
- R8: If a word completes while rxValid is set and not being acknowledged, overrun is set, rxData keeps the earlier word and the new word is dropped.
- R9: If select goes inactive after at least one bit but before the word is complete, modeFault is set, the partial word is discarded, and the next transfer starts again from bit 0.
- R10: modeFault and overrun stay set until errClear is pulsed, and errClear returns them to 0.
- R11: Edges on sck while select is inactive change neither the received data nor the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the controller |
| mosi | input | 1 | Serial data from the controller |
| ss | input | 1 | Select from the controller |
| miso | output | 1 | Serial data to the controller |
| misoOe | output | 1 | Output enable for miso (low models high impedance) |
| cfgCpol | input | 1 | Idle level of sck |
| cfgCpha | input | 1 | 0: sample on first edge, 1: sample on second edge |
| cfgLen | input | 2 | Word length: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| cfgLsbFirst | input | 1 | 1: LSB first, 0: MSB first |
| cfgSsActHigh | input | 1 | 1: select active high, 0: active low |
| txData | input | 32 | Next word to send |
| txLoad | input | 1 | Captures txData into the holding word |
| rxData | output | 32 | Last accepted received word, right-aligned |
| rxValid | output | 1 | rxData holds an unread word |
| rxAck | input | 1 | Marks rxData as read |
| modeFault | output | 1 | Sticky: select dropped mid-word |
| overrun | output | 1 | Sticky: a word arrived while the previous one was unread |
| errClear | input | 1 | Clears both error flags |

## Verification
The hardest state to reach is a completed word that meets an unread earlier word, together with recovery from a select dropped mid-word. In that situation the bit counter, the held word and both flags all have to behave. The stimulus gets there by driving a controller that stops after five bits and drops select, then sends a full word without acknowledging it, then sends another. The sticky flags and the preserved word are checked before each flag is cleared. A separate scenario toggles sck while select is idle and then sends a clean word. A stray count left over from those idle edges would corrupt that word.

// File: rtl/spis_pkg.sv
package spis_pkg;
  localparam int MAX_W = 32;
  localparam int CNT_W = $clog2(MAX_W);

  // strobes from control to datapath
  typedef struct packed {
    logic sampleBit;   // take one mosi bit into the receive shifter
    logic firstBit;    // this sample starts a new word
    logic captureWord; // copy the finished word to rxData
    logic shiftTx;     // advance the transmit shifter
    logic loadTx;      // refill the transmit shifter from the holding word
  } spisStrobe_t;

  function automatic logic [CNT_W-1:0] lastIdx(input logic [1:0] lenSel);
    case (lenSel)
      2'd0:    return CNT_W'(7);
      2'd1:    return CNT_W'(15);
      default: return CNT_W'(MAX_W - 1);
    endcase
  endfunction
endpackage

// File: rtl/spis_ctrl.sv
module spis_ctrl
  import spis_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck,
  input  logic        ss,
  input  logic        cfgCpol,
  input  logic        cfgCpha,
  input  logic [1:0]  cfgLen,
  input  logic        cfgSsActHigh,
  input  logic        rxAck,
  input  logic        errClear,
  output spisStrobe_t strobe,
  output logic        selActive,
  output logic        rxValid,
  output logic        modeFault,
  output logic        overrun
);
  logic [SYNC_STAGES-1:0] sckSyn, selSyn;
  logic sckPrev, selPrev, selIn;
  logic [CNT_W-1:0] rxCnt, txCnt, lastBit;
  logic sckNow, riseEdge, fallEdge, leadEdge, trailEdge;
  logic sampEdge, shiftEdge, selRise, selFall, rxDone, txBoundary;

  // select is turned into "active" before the synchronizer so reset means idle
  assign selIn = cfgSsActHigh ? ss : ~ss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckSyn  <= '0;
      selSyn  <= '0;
      sckPrev <= 1'b0;
      selPrev <= 1'b0;
    end else begin
      sckSyn  <= {sckSyn[SYNC_STAGES-2:0], sck};
      selSyn  <= {selSyn[SYNC_STAGES-2:0], selIn};
      sckPrev <= sckNow;
      selPrev <= selActive;
    end
  end

  assign sckNow    = sckSyn[SYNC_STAGES-1];
  assign selActive = selSyn[SYNC_STAGES-1];
  assign riseEdge  = sckNow & ~sckPrev;
  assign fallEdge  = ~sckNow & sckPrev;
  assign leadEdge  = cfgCpol ? fallEdge : riseEdge;
  assign trailEdge = cfgCpol ? riseEdge : fallEdge;
  assign sampEdge  = selActive & (cfgCpha ? trailEdge : leadEdge);
  assign shiftEdge = selActive & (cfgCpha ? leadEdge : trailEdge);
  assign selRise   = selActive & ~selPrev;
  assign selFall   = ~selActive & selPrev;
  assign lastBit   = lastIdx(cfgLen);
  assign rxDone    = sampEdge & (rxCnt == lastBit);
  // phase 1 refills on the first shift edge of a word, phase 0 after the last
  assign txBoundary = cfgCpha ? (txCnt == '0) : (txCnt == lastBit);

  always_comb begin
    strobe.sampleBit   = sampEdge;
    strobe.firstBit    = (rxCnt == '0);
    strobe.captureWord = rxDone & (~rxValid | rxAck);
    strobe.loadTx      = selRise | (shiftEdge & txBoundary);
    strobe.shiftTx     = shiftEdge & ~txBoundary;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxCnt <= '0;
      txCnt <= '0;
    end else begin
      if (!selActive)    rxCnt <= '0;
      else if (sampEdge) rxCnt <= rxDone ? '0 : rxCnt + 1'b1;

      if (!selActive || selRise) txCnt <= '0;
      else if (shiftEdge)        txCnt <= (txCnt == lastBit) ? '0 : txCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxValid   <= 1'b0;
      modeFault <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (strobe.captureWord) rxValid <= 1'b1;
      else if (rxAck)         rxValid <= 1'b0;

      if (selFall && rxCnt != '0) modeFault <= 1'b1;
      else if (errClear)          modeFault <= 1'b0;

      if (rxDone && rxValid && !rxAck) overrun <= 1'b1;
      else if (errClear)               overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/spis_dp.sv
module spis_dp
  import spis_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mosi,
  input  logic [1:0]       cfgLen,
  input  logic             cfgLsbFirst,
  input  logic             selActive,
  input  spisStrobe_t      strobe,
  input  logic [MAX_W-1:0] txData,
  input  logic             txLoad,
  output logic [MAX_W-1:0] rxData,
  output logic             miso
);
  logic [SYNC_STAGES-1:0] mosiSyn;
  logic [MAX_W-1:0] txHold, txShift, rxShift, rxBase, rxNext;
  logic [CNT_W-1:0] lastBit;
  logic mosiNow;

  assign lastBit = lastIdx(cfgLen);
  assign mosiNow = mosiSyn[SYNC_STAGES-1];

  always_comb begin
    rxBase = strobe.firstBit ? '0 : rxShift;
    if (cfgLsbFirst) rxNext = (rxBase >> 1) | (MAX_W'(mosiNow) << lastBit);
    else             rxNext = {rxBase[MAX_W-2:0], mosiNow};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mosiSyn <= '0;
      txHold  <= '0;
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
    end else begin
      mosiSyn <= {mosiSyn[SYNC_STAGES-2:0], mosi};
      if (txLoad) txHold <= txData;
      if (strobe.loadTx)       txShift <= txHold;
      else if (strobe.shiftTx) txShift <= cfgLsbFirst ? (txShift >> 1) : (txShift << 1);
      if (strobe.sampleBit)   rxShift <= rxNext;
      if (strobe.captureWord) rxData  <= rxNext;
    end
  end

  assign miso = selActive & (cfgLsbFirst ? txShift[0] : txShift[lastBit]);
endmodule

// File: rtl/spis_top.sv
module spis_top
  import spis_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             mosi,
  input  logic             ss,
  output logic             miso,
  output logic             misoOe,
  input  logic             cfgCpol,
  input  logic             cfgCpha,
  input  logic [1:0]       cfgLen,
  input  logic             cfgLsbFirst,
  input  logic             cfgSsActHigh,
  input  logic [MAX_W-1:0] txData,
  input  logic             txLoad,
  output logic [MAX_W-1:0] rxData,
  output logic             rxValid,
  input  logic             rxAck,
  output logic             modeFault,
  output logic             overrun,
  input  logic             errClear
);
  spisStrobe_t strobe;
  logic selActive;

  spis_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ss(ss),
    .cfgCpol(cfgCpol), .cfgCpha(cfgCpha), .cfgLen(cfgLen),
    .cfgSsActHigh(cfgSsActHigh), .rxAck(rxAck), .errClear(errClear),
    .strobe(strobe), .selActive(selActive), .rxValid(rxValid),
    .modeFault(modeFault), .overrun(overrun)
  );

  spis_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rst_n(rst_n), .mosi(mosi), .cfgLen(cfgLen),
    .cfgLsbFirst(cfgLsbFirst), .selActive(selActive), .strobe(strobe),
    .txData(txData), .txLoad(txLoad), .rxData(rxData), .miso(miso)
  );

  assign misoOe = selActive;
endmodule

// File: rtl/spis_chk.sv
module spis_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        miso,
  input logic        misoOe,
  input logic        rxValid,
  input logic        rxAck,
  input logic [31:0] rxData,
  input logic        modeFault,
  input logic        overrun,
  input logic        errClear
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !misoOe |-> !miso);

  // R8
  held_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid && !rxAck |=> rxValid && $stable(rxData));

  // R10
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modeFault && !errClear |=> modeFault);

  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !errClear |=> overrun);

  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxValid) |-> $past(rxAck));
endmodule

bind spis_top spis_chk chk_i (
  .clk(clk), .rst_n(rst_n), .miso(miso), .misoOe(misoOe),
  .rxValid(rxValid), .rxAck(rxAck), .rxData(rxData),
  .modeFault(modeFault), .overrun(overrun), .errClear(errClear)
);

// File: tb/tb_spis_top.sv
module tb_spis_top;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, ss = 1'b1;
  logic cfgCpol = 1'b0, cfgCpha = 1'b0, cfgLsbFirst = 1'b0, cfgSsActHigh = 1'b0;
  logic [1:0] cfgLen = 2'd0;
  logic [31:0] txData = '0;
  logic txLoad = 1'b0, rxAck = 1'b0, errClear = 1'b0;
  logic miso, misoOe, rxValid, modeFault, overrun;
  logic [31:0] rxData;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  spis_top dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .ss(ss),
    .miso(miso), .misoOe(misoOe), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha),
    .cfgLen(cfgLen), .cfgLsbFirst(cfgLsbFirst), .cfgSsActHigh(cfgSsActHigh),
    .txData(txData), .txLoad(txLoad), .rxData(rxData), .rxValid(rxValid),
    .rxAck(rxAck), .modeFault(modeFault), .overrun(overrun), .errClear(errClear)
  );

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic loadTx(input logic [31:0] w);
    txData = w; txLoad = 1'b1; ticks(1); txLoad = 1'b0; ticks(1);
  endtask

  task automatic pulseAck();
    rxAck = 1'b1; ticks(1); rxAck = 1'b0; ticks(1);
  endtask

  task automatic pulseClear();
    errClear = 1'b1; ticks(1); errClear = 1'b0; ticks(1);
  endtask

  task automatic selOn();
    sck = cfgCpol; ss = cfgSsActHigh; ticks(HALF);
  endtask

  task automatic selOff();
    ss = ~cfgSsActHigh; ticks(HALF);
  endtask

  function automatic int lenOf(input logic [1:0] sel);
    return sel == 2'd0 ? 8 : (sel == 2'd1 ? 16 : 32);
  endfunction

  // controller side of one word; nb < length leaves the word unfinished
  task automatic xfer(input logic [31:0] mo, input int nb, output logic [31:0] mi);
    int len = lenOf(cfgLen);
    mi = '0;
    for (int i = 0; i < nb; i++) begin
      int idx = cfgLsbFirst ? i : len - 1 - i;
      if (!cfgCpha) begin
        mosi = mo[idx]; ticks(HALF);
        mi[idx] = miso; sck = ~cfgCpol; ticks(HALF);
        sck = cfgCpol;
      end else begin
        sck = ~cfgCpol; mosi = mo[idx]; ticks(HALF);
        mi[idx] = miso; sck = cfgCpol; ticks(HALF);
      end
    end
    ticks(HALF);
  endtask

  task automatic testReset();
    chkEq("R1 rxValid", {31'b0, rxValid}, 32'h0);
    chkEq("R1 modeFault", {31'b0, modeFault}, 32'h0);
    chkEq("R1 overrun", {31'b0, overrun}, 32'h0);
    chkEq("R1 misoOe", {31'b0, misoOe}, 32'h0);
    chkEq("R1 miso", {31'b0, miso}, 32'h0);
  endtask

  task automatic testBasic();
    logic [31:0] mi;
    cfgCpol = 0; cfgCpha = 0; cfgLen = 2'd0; cfgLsbFirst = 0;
    loadTx(32'hA5);
    selOn();
    chkEq("R2 misoOe active", {31'b0, misoOe}, 32'h1);
    xfer(32'h3C, 8, mi);
    selOff();
    chkEq("R3 R4 rx mode0 8bit", rxData, 32'h3C);
    chkEq("R6 miso mode0 8bit", mi, 32'hA5);
    chkEq("R7 valid set", {31'b0, rxValid}, 32'h1);
    pulseAck();
    chkEq("R7 ack clears", {31'b0, rxValid}, 32'h0);
  endtask

  task automatic testModes();
    logic [31:0] mi;
    cfgLen = 2'd1; cfgLsbFirst = 0;
    for (int m = 0; m < 4; m++) begin
      cfgCpol = m[1]; cfgCpha = m[0];
      loadTx(32'h1234 + m);
      selOn();
      xfer(32'hA5C3 ^ m, 16, mi);
      selOff();
      chkEq($sformatf("R3 R4 rx mode%0d", m), rxData, 32'hA5C3 ^ m);
      chkEq($sformatf("R3 miso mode%0d", m), mi, 32'h1234 + m);
      pulseAck();
    end
  endtask

  task automatic testLsb32();
    logic [31:0] mi;
    cfgCpol = 1; cfgCpha = 0; cfgLen = 2'd2; cfgLsbFirst = 1;
    loadTx(32'h8000_0001);
    selOn();
    xfer(32'hDEAD_BEEF, 32, mi);
    selOff();
    chkEq("R5 R4 rx lsb 32bit", rxData, 32'hDEAD_BEEF);
    chkEq("R5 miso lsb 32bit", mi, 32'h8000_0001);
    pulseAck();
    cfgLen = 2'd0;
    loadTx(32'h0000_0081);
    selOn();
    xfer(32'h0000_0001, 8, mi);
    selOff();
    chkEq("R5 rx lsb 8bit", rxData, 32'h01);
    chkEq("R5 miso lsb 8bit", mi, 32'h81);
    pulseAck();
    cfgLsbFirst = 0;
  endtask

  task automatic testBackToBack();
    logic [31:0] mi;
    cfgCpol = 1; cfgCpha = 1; cfgLen = 2'd0;
    loadTx(32'h3C);
    selOn();
    xfer(32'h11, 8, mi);
    chkEq("R6 first word", mi, 32'h3C);
    pulseAck();
    loadTx(32'hC6);
    xfer(32'h22, 8, mi);
    chkEq("R6 reloaded word", mi, 32'hC6);
    chkEq("R6 second rx", rxData, 32'h22);
    pulseAck();
    xfer(32'h33, 8, mi);
    chkEq("R6 held word reused", mi, 32'hC6);
    selOff();
    pulseAck();
  endtask

  task automatic testFaults();
    logic [31:0] mi;
    cfgCpol = 0; cfgCpha = 0; cfgLen = 2'd0;
    selOn();
    xfer(32'hFF, 5, mi);
    selOff();
    chkEq("R9 fault set", {31'b0, modeFault}, 32'h1);
    chkEq("R9 no partial word", {31'b0, rxValid}, 32'h0);
    selOn();
    xfer(32'h96, 8, mi);
    selOff();
    chkEq("R9 restart at bit0", rxData, 32'h96);
    chkEq("R10 fault still set", {31'b0, modeFault}, 32'h1);
    selOn();
    xfer(32'h11, 8, mi);
    selOff();
    chkEq("R8 overrun set", {31'b0, overrun}, 32'h1);
    chkEq("R8 old word kept", rxData, 32'h96);
    chkEq("R8 still valid", {31'b0, rxValid}, 32'h1);
    pulseClear();
    chkEq("R10 clear fault", {31'b0, modeFault}, 32'h0);
    chkEq("R10 clear overrun", {31'b0, overrun}, 32'h0);
    pulseAck();
  endtask

  task automatic testIdleSck();
    logic [31:0] mi;
    cfgCpol = 0; cfgCpha = 0; cfgLen = 2'd0;
    for (int i = 0; i < 10; i++) begin
      mosi = i[0]; sck = ~sck; ticks(HALF);
    end
    chkEq("R11 no word from idle edges", {31'b0, rxValid}, 32'h0);
    chkEq("R2 oe low idle", {31'b0, misoOe}, 32'h0);
    selOn();
    xfer(32'h5A, 8, mi);
    selOff();
    chkEq("R11 count untouched", rxData, 32'h5A);
    pulseAck();
  endtask

  task automatic testActiveHigh();
    logic [31:0] mi;
    ss = 1'b0; cfgSsActHigh = 1'b1; ticks(HALF);
    chkEq("R2 high pol idle oe", {31'b0, misoOe}, 32'h0);
    chkEq("R2 high pol idle miso", {31'b0, miso}, 32'h0);
    loadTx(32'hE7);
    selOn();
    chkEq("R2 high pol active oe", {31'b0, misoOe}, 32'h1);
    xfer(32'h4B, 8, mi);
    selOff();
    chkEq("R2 high pol rx", rxData, 32'h4B);
    chkEq("R2 high pol miso", mi, 32'hE7);
    pulseAck();
  endtask

  bit done = 0;

  initial begin
    ticks(3);
    rst_n = 1'b1;
    ticks(3);
    testReset();
    testBasic();
    testModes();
    testLsb32();
    testBackToBack();
    testFaults();
    testIdleSck();
    testActiveHigh();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule